// File: doc/BRIEF.md
# Age-Counter Replacement Picker

This block keeps an approximate recency record for every row of a cache and names a row to evict when asked. Each row owns a small saturating age counter. The counter climbs by one on every clock and stops at its maximum. Touching the row clears it to zero. A row that has not been used for a long time therefore reads as all ones, and a row that was just used reads near zero.

When the cache controller misses, it pulses a request. The picker then compares every counter against a pattern, one pattern per clock. The first pattern demands that all bits are ones. Each later pattern stops caring about one more low-order bit, and the last pattern cares about none. The first pattern that hits at least one row is kept as a hit vector. The picker then walks that vector from row 0 upward, one row per clock, and reports the first set row. This takes several clocks, which is acceptable because the picker runs alongside the slow refill from main memory.

Top module: `lru_age_victim`

## Requirements
- R1: After reset every age counter reads all ones, `vict_valid` is low and `vict_row` is 0.
- R2: On every clock edge each counter that is not being accessed goes up by one, and it stays at all ones once it gets there.
- R3: When `acc_valid` is high at an edge, the counter of row `acc_row` becomes 0 at that edge. This overrides the increment.
- R4: A request accepted at edge E starts the search. At edge E+1+k the search applies step k (k = 0..AGE_W). A row matches step k when its AGE_W−k most significant age bits are all ones; its low k bits are ignored. Matching uses the counter values held just before that edge.
- R5: Step AGE_W ignores every bit, so a search always ends with at least one matching row and always produces a victim.
- R6: Among the rows that match the first successful step, the lowest index is reported. The scan tests one row per clock, so if the search stops at step k and the victim is row v, `vict_valid` rises at edge E+k+2+v.
- R7: `vict_valid` is high for exactly one cycle per accepted request. `vict_row` changes only when `vict_valid` rises, and it holds its value until the next pulse.
- R8: A `vict_req` pulse that arrives while a search or scan is in progress is ignored and produces no extra victim.
- R9: An access made during the scan updates the counters, but it does not change the victim of the scan in progress.
- R10: From an accepted request to its `vict_valid` pulse, at most AGE_W+ROWS+2 cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A row is accessed this cycle |
| acc_row | input | $clog2(ROWS) | Index of the accessed row |
| vict_req | input | 1 | Start a victim search (ignored while busy) |
| vict_valid | output | 1 | One-cycle pulse: victim index is ready |
| vict_row | output | $clog2(ROWS) | Selected victim row, held between pulses |

## Verification
The hardest case to reach is a search that falls through to the deeper masked steps, and above all to the step that ignores every bit. That case needs every row to have been touched within the last few cycles. With one access per clock, this cannot happen when there are more rows than the counter span. The bench therefore uses an 8-row instance. It sweeps all rows back to back just before a request, and it mixes random access bursts with idle gaps so that searches end at a range of steps. The bench also fires an access to the pending victim row in the middle of a long scan. It sends a second request during a scan as well, and confirms that neither one changes the outcome.

// File: rtl/lru_age_victim.sv
module lru_age_victim #(
  parameter int ROWS  = 256,
  parameter int AGE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [$clog2(ROWS)-1:0] acc_row,
  input  logic                    vict_req,
  output logic                    vict_valid,
  output logic [$clog2(ROWS)-1:0] vict_row
);
  localparam int IDX_W = $clog2(ROWS);
  localparam int LVL_W = $clog2(AGE_W + 1);

  typedef enum logic [1:0] {IDLE, SEARCH, SCAN} state_t;

  state_t             state;
  logic [AGE_W-1:0]   age [ROWS];
  logic [LVL_W-1:0]   lvl;
  logic [AGE_W-1:0]   care;
  logic [ROWS-1:0]    hit_now, hit_q;
  logic [IDX_W-1:0]   ptr;

  assign care = {AGE_W{1'b1}} << lvl;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        age[i] <= '1;
      else if (acc_valid && acc_row == IDX_W'(i))
        age[i] <= '0;
      else if (age[i] != '1)
        age[i] <= age[i] + 1'b1;
    end
    assign hit_now[i] = (age[i] & care) == care;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      lvl        <= '0;
      hit_q      <= '0;
      ptr        <= '0;
      vict_valid <= 1'b0;
      vict_row   <= '0;
    end else begin
      vict_valid <= 1'b0;
      case (state)
        IDLE: if (vict_req) begin
          state <= SEARCH;
          lvl   <= '0;
        end
        SEARCH: if (|hit_now) begin
          hit_q <= hit_now;
          ptr   <= '0;
          state <= SCAN;
        end else begin
          lvl <= lvl + 1'b1;
        end
        SCAN: if (hit_q[ptr]) begin
          vict_valid <= 1'b1;
          vict_row   <= ptr;
          state      <= IDLE;
        end else begin
          ptr <= ptr + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module lru_age_victim_chk #(
  parameter int ROWS  = 256,
  parameter int AGE_W = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    vict_req,
  input logic                    vict_valid,
  input logic [$clog2(ROWS)-1:0] vict_row
);
  logic busy;
  int   wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wait_cnt <= 0;
    end else begin
      if (vict_valid)    busy <= 1'b0;
      else if (vict_req) busy <= 1'b1;
      wait_cnt <= busy ? wait_cnt + 1 : 0;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |=> !vict_valid);  // R7
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vict_valid |-> $stable(vict_row));  // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> busy);  // R8
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= AGE_W + ROWS + 2);  // R10
endmodule

bind lru_age_victim lru_age_victim_chk #(.ROWS(ROWS), .AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vict_req(vict_req),
  .vict_valid(vict_valid), .vict_row(vict_row));

// File: tb/lru_age_victim_test.sv
module lru_age_victim_test;
  localparam int ROWS  = 8;
  localparam int AGE_W = 5;
  localparam int IDX_W = $clog2(ROWS);
  localparam int AMAX  = (1 << AGE_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [IDX_W-1:0] acc_row = '0;
  logic             vict_req = 1'b0;
  logic             vict_valid;
  logic [IDX_W-1:0] vict_row;

  lru_age_victim #(.ROWS(ROWS), .AGE_W(AGE_W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
    .vict_req(vict_req), .vict_valid(vict_valid), .vict_row(vict_row));

  always #10 clk = ~clk;

  typedef struct { int row; int cyc; string tag; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0, cyc = 0;
  int   mage [ROWS];

  // model of the counters from R1..R3
  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < ROWS; i++) begin
      if (!rst_n) mage[i] = AMAX;
      else if (acc_valid && int'(acc_row) == i) mage[i] = 0;
      else if (mage[i] < AMAX) mage[i] = mage[i] + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (vict_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: unexpected victim pulse row=%0d expected none", vict_row);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(vict_row) != e.row || cyc != e.cyc) begin
          n_bad++;
          $display("FAIL %s: row=%0d cyc=%0d expected row=%0d cyc=%0d",
                   e.tag, vict_row, cyc, e.row, e.cyc);
        end
      end
    end
  end

  task automatic access(input int r);
    acc_valid = 1'b1;
    acc_row   = IDX_W'(r);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // R4/R5/R6 prediction from the requirements
  task automatic predict(output int row, output int lat);
    int a [ROWS];
    row = -1;
    for (int i = 0; i < ROWS; i++) a[i] = mage[i] < AMAX ? mage[i] + 1 : AMAX;
    for (int k = 0; k <= AGE_W && row < 0; k++) begin
      int thr;
      thr = AMAX & ~((1 << k) - 1);
      for (int i = 0; i < ROWS && row < 0; i++)
        if ((a[i] & thr) == thr) begin row = i; lat = 1 + k + 2 + i; end
      for (int i = 0; i < ROWS; i++) if (a[i] < AMAX) a[i] = a[i] + 1;
    end
  endtask

  task automatic request(input string tag);
    exp_t e;
    int r, l;
    predict(r, l);
    e.row = r; e.cyc = cyc + l; e.tag = tag;
    exp_q.push_back(e);
    vict_req = 1'b1;
    @(negedge clk);
    vict_req = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (vict_valid !== 1'b0 || vict_row !== '0) begin
      n_bad++;
      $display("FAIL R1: valid=%0b row=%0d expected 0/0", vict_valid, vict_row);
    end
    request("R1"); drain();
    access(0); request("R3"); drain();
    repeat (4) begin
      for (int i = 0; i < ROWS; i++) access(i);
      request("R5");
      drain();
    end
    for (int i = ROWS - 1; i >= 0; i--) access(i);
    request("R4"); drain();
    repeat (40) @(negedge clk);
    access(2); access(6); request("R2"); drain();
    for (int i = 0; i < ROWS - 1; i++) access(i);
    request("R9");
    repeat (4) @(negedge clk);
    access(ROWS - 1); access(1);
    vict_req = 1'b1; @(negedge clk); vict_req = 1'b0;
    drain();
    request("R9"); drain();
    for (int i = 0; i < ROWS - 1; i++) access(i);
    request("R8");
    repeat (2) @(negedge clk);
    vict_req = 1'b1; @(negedge clk); vict_req = 1'b0;
    drain(); repeat (20) @(negedge clk);
    for (int t = 0; t < 30; t++) begin
      int n;
      n = int'($urandom_range(0, 20));
      for (int j = 0; j < n; j++) begin
        if ($urandom_range(0, 3) != 0) access(int'($urandom_range(0, ROWS - 1)));
        else @(negedge clk);
      end
      request("R6");
      drain();
    end
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d victims missing expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10: watchdog expired, pending=%0d expected 0", exp_q.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule